// File: doc/BRIEF.md
# Misaligned Word-to-Halfword Access Splitter

This block connects a 32-bit host port to a register space made of 16-bit locations, each at an even byte address. A 32-bit host access is broken into a short series of peripheral cycles, and each cycle enables only the byte lanes it needs. A word access at an even address becomes two full halfword cycles. A word access at an odd address becomes three cycles: a single low byte, one aligned halfword, and then a single high byte. For reads, the block collects the returned bytes and halfwords into one 32-bit result.

Byte and halfword host accesses pass through as a single peripheral cycle. Only one host access is handled at a time. While an access is in progress the host sees `req_ready` low. A one-cycle `req_done` pulse marks the end of each access. The peripheral side has no wait states: it returns read data in the same cycle as the strobe and accepts write data on the clock edge that ends the strobe cycle.

Top module: `hw_split32`

## Requirements
- R1: A word access (`req_size[1]`=1) at an even address A produces exactly two strobe cycles, at locations A and A+2, each with `per_be`=2'b11.
- R2: A word access at an odd address A produces exactly three strobe cycles: location A-1 with `per_be`=2'b01, then A+1 with 2'b11, then A+3 with 2'b10.
- R3: Byte order is big-endian. Host byte `req_wdata[31:24]` goes to byte address A, `[23:16]` to A+1, `[15:8]` to A+2 and `[7:0]` to A+3. On the peripheral side, `per_be[1]` and `per_wdata[15:8]` serve the even byte of a location, and `per_be[0]` and `per_wdata[7:0]` serve the odd byte.
- R4: A word read returns the byte at A in `req_rdata[31:24]`, A+1 in `[23:16]`, A+2 in `[15:8]` and A+3 in `[7:0]`.
- R5: A byte access (`req_size`=2'b00) is one strobe cycle at location A with bit 0 cleared. `per_be` is 2'b10 for an even A and 2'b01 for an odd A. The write byte comes from `req_wdata[7:0]`. A read returns the byte zero-extended in `req_rdata[7:0]`.
- R6: A halfword access (`req_size`=2'b01) ignores address bit 0. It is one strobe cycle with `per_be`=2'b11 and takes its write data from `req_wdata[15:0]`. A read returns the halfword zero-extended in `req_rdata[15:0]`.
- R7: `req_ready` is low from the clock that accepts a request until the last strobe cycle ends. A request presented while `req_ready` is low is ignored.
- R8: Strobe cycles of one access occur on consecutive clocks. `req_done` is high for exactly one cycle, in the clock after the last strobe cycle.
- R9: Accepting a request clears `req_rdata`. It stays at zero after a write. After the last cycle of a read it holds its value until the next accepted request.
- R10: Location addresses wrap modulo 2^ADDR_W.
- R11: After reset, `req_ready`=1 and `per_stb`, `req_done` and `req_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe, taken when `req_ready` is high |
| req_addr | input | ADDR_W | Host byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Host write data |
| req_ready | output | 1 | Idle, so a new request can be taken |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Assembled read data |
| per_stb | output | 1 | Peripheral cycle strobe |
| per_we | output | 1 | Peripheral write enable |
| per_addr | output | ADDR_W | Even location address |
| per_be | output | 2 | Lane enables: [1] even byte, [0] odd byte |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data, valid during the strobe |

## Verification
The assertions assume the peripheral answers in the same cycle as the strobe, with no stall. They also assume reset is held for more than one clock, so that past values are defined. The bench's memory model answers combinationally and applies writes on the edge that ends each strobe cycle, so the first assumption always holds. Extra requests driven while the block is busy are dropped before the block becomes ready again. This keeps the one-access-at-a-time assumption intact while still testing that such requests are ignored.

// File: rtl/split_pkg.sv
package split_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORDX = 2'b11
    } size_e;

    typedef struct packed {
        size_e       size;
        logic        odd;
        logic        write;
        logic [31:0] wdata;
    } cmd_t;

    function automatic logic is_word(input cmd_t c);
        return c.size[1];
    endfunction

    function automatic logic [1:0] beat_count(input cmd_t c);
        if (is_word(c)) return c.odd ? 2'd3 : 2'd2;
        return 2'd1;
    endfunction

    function automatic logic [1:0] beat_lanes(input cmd_t c, input logic [1:0] i);
        if (is_word(c)) begin
            if (!c.odd) return 2'b11;
            case (i)
                2'd0:    return 2'b01;
                2'd1:    return 2'b11;
                default: return 2'b10;
            endcase
        end
        if (c.size == SZ_HALF) return 2'b11;
        return c.odd ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [15:0] beat_wdata(input cmd_t c, input logic [1:0] i);
        if (is_word(c)) begin
            if (!c.odd) return (i == 2'd0) ? c.wdata[31:16] : c.wdata[15:0];
            case (i)
                2'd0:    return {8'h00, c.wdata[31:24]};
                2'd1:    return c.wdata[23:8];
                default: return {c.wdata[7:0], 8'h00};
            endcase
        end
        if (c.size == SZ_HALF) return c.wdata[15:0];
        return {c.wdata[7:0], c.wdata[7:0]};
    endfunction

    function automatic logic [31:0] merge_read(input cmd_t c, input logic [1:0] i,
                                               input logic [31:0] old, input logic [15:0] r);
        if (is_word(c)) begin
            if (!c.odd) return (i == 2'd0) ? {r, old[15:0]} : {old[31:16], r};
            case (i)
                2'd0:    return {r[7:0], old[23:0]};
                2'd1:    return {old[31:24], r, old[7:0]};
                default: return {old[31:8], r[15:8]};
            endcase
        end
        if (c.size == SZ_HALF) return {16'h0000, r};
        return {24'h000000, c.odd ? r[7:0] : r[15:8]};
    endfunction

endpackage

// File: rtl/split_seq.sv
module split_seq
    import split_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              ready,
    output logic              accept,
    output logic              active,
    output logic              done,
    output logic [1:0]        idx,
    output cmd_t              cmd,
    output logic [ADDR_W-1:0] loc
);
    localparam logic [ADDR_W-1:0] LOC_STEP = ADDR_W'(2);

    logic              busy_q;
    logic              done_q;
    logic [1:0]        idx_q;
    cmd_t              cmd_q;
    logic [ADDR_W-1:0] loc_q;
    logic              last_beat;

    assign ready     = !busy_q;
    assign accept    = req_valid && !busy_q;
    assign last_beat = (idx_q == beat_count(cmd_q) - 2'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= 2'd0;
            cmd_q  <= '0;
            loc_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q      <= 1'b1;
                idx_q       <= 2'd0;
                cmd_q.size  <= size_e'(req_size);
                cmd_q.odd   <= req_addr[0];
                cmd_q.write <= req_write;
                cmd_q.wdata <= req_wdata;
                loc_q       <= {req_addr[ADDR_W-1:1], 1'b0};
            end else if (busy_q) begin
                if (last_beat) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 2'd1;
                    loc_q <= loc_q + LOC_STEP;
                end
            end
        end
    end

    assign active = busy_q;
    assign done   = done_q;
    assign idx    = idx_q;
    assign cmd    = cmd_q;
    assign loc    = loc_q;

    a_r8_done_after_beat: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(busy_q));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    a_r8_beats_back_to_back: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> (busy_q || done_q));
    a_r7_cmd_held: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(cmd_q));
    a_r10_loc_steps: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> (loc_q == ADDR_W'($past(loc_q) + LOC_STEP)));

endmodule

// File: rtl/split_lane.sv
module split_lane
    import split_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        active,
    input  cmd_t        cmd,
    input  logic [1:0]  idx,
    output logic [1:0]  be,
    output logic [15:0] wdata
);
    always_comb begin
        be    = 2'b00;
        wdata = 16'h0000;
        if (active) begin
            be = beat_lanes(cmd, idx);
            if (cmd.write) wdata = beat_wdata(cmd, idx);
        end
    end

    a_r1_even_full_lanes: assert property (@(posedge clk) disable iff (rst)
        (active && cmd.size[1] && !cmd.odd) |-> (be == 2'b11));
    a_r2_odd_edge_single: assert property (@(posedge clk) disable iff (rst)
        (active && cmd.size[1] && cmd.odd && idx != 2'd1) |-> ($countones(be) == 1));
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !active |-> (be == 2'b00 && wdata == 16'h0000));

endmodule

// File: rtl/split_gather.sv
module split_gather
    import split_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        capture,
    input  cmd_t        cmd,
    input  logic [1:0]  idx,
    input  logic [15:0] per_rdata,
    output logic [31:0] rdata
);
    logic [31:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst)          acc_q <= '0;
        else if (clear)   acc_q <= '0;
        else if (capture) acc_q <= merge_read(cmd, idx, acc_q, per_rdata);
    end

    assign rdata = acc_q;

    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        (!clear && !capture) |=> $stable(acc_q));
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc_q == 32'h0));

endmodule

// File: rtl/hw_split32.sv
module hw_split32
    import split_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic              req_done,
    output logic [31:0]       req_rdata,
    output logic              per_stb,
    output logic              per_we,
    output logic [ADDR_W-1:0] per_addr,
    output logic [1:0]        per_be,
    output logic [15:0]       per_wdata,
    input  logic [15:0]       per_rdata
);
    logic        accept;
    logic        active;
    logic [1:0]  idx;
    cmd_t        cmd;

    split_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_wdata(req_wdata),
        .ready(req_ready), .accept(accept), .active(active), .done(req_done),
        .idx(idx), .cmd(cmd), .loc(per_addr)
    );

    split_lane u_lane (
        .clk(clk), .rst(rst), .active(active), .cmd(cmd), .idx(idx),
        .be(per_be), .wdata(per_wdata)
    );

    split_gather u_gather (
        .clk(clk), .rst(rst), .clear(accept),
        .capture(active && !cmd.write), .cmd(cmd), .idx(idx),
        .per_rdata(per_rdata), .rdata(req_rdata)
    );

    assign per_stb = active;
    assign per_we  = active && cmd.write;

    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (per_stb && !req_done) |=> (!req_ready || req_done));
    a_r6_even_location: assert property (@(posedge clk) disable iff (rst)
        per_stb |-> (per_addr[0] == 1'b0));

endmodule

// File: tb/sim_hw_split32.sv
module sim_hw_split32;
    localparam int AW = 8;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'b00;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready, req_done, per_stb, per_we;
    logic [31:0]   req_rdata;
    logic [AW-1:0] per_addr;
    logic [1:0]    per_be;
    logic [15:0]   per_wdata, per_rdata;

    logic [7:0] mem   [NB];
    logic [7:0] exp_m [NB];

    int checks = 0;
    int errors = 0;
    int n_beats;
    logic [AW-1:0] b_addr [4];
    logic [1:0]    b_be   [4];
    logic [15:0]   b_wd   [4];

    always #5 clk = ~clk;

    hw_split32 #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_done(req_done), .req_rdata(req_rdata),
        .per_stb(per_stb), .per_we(per_we), .per_addr(per_addr), .per_be(per_be),
        .per_wdata(per_wdata), .per_rdata(per_rdata)
    );

    assign per_rdata = {mem[per_addr], mem[per_addr + AW'(1)]};

    always @(posedge clk) begin
        if (per_stb && per_we) begin
            if (per_be[1]) mem[per_addr]         <= per_wdata[15:8];
            if (per_be[0]) mem[per_addr + AW'(1)] <= per_wdata[7:0];
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Runs one host access starting at a negedge; optional noise request while busy.
    task automatic xact(input logic [AW-1:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, input logic noise);
        logic seen_done;
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = noise;
        req_addr  = a + AW'(5); req_size = 2'b10; req_write = 1'b1; req_wdata = 32'hDEAD_BEEF;
        n_beats = 0;
        seen_done = 1'b0;
        for (int k = 0; k < 8 && !seen_done; k++) begin
            if (per_stb) begin
                if (n_beats < 4) begin
                    b_addr[n_beats] = per_addr; b_be[n_beats] = per_be; b_wd[n_beats] = per_wdata;
                end
                n_beats = n_beats + 1;
                chk(req_ready == 1'b0, "R7 ready low while busy", {31'h0, req_ready}, 32'h0);
                chk(req_done == 1'b0, "R8 no done during beat", {31'h0, req_done}, 32'h0);
            end
            if (req_done) begin
                seen_done = 1'b1;
                chk(per_stb == 1'b0, "R8 done after last beat", {31'h0, per_stb}, 32'h0);
                chk(req_ready == 1'b1, "R7 ready at done", {31'h0, req_ready}, 32'h1);
            end else begin
                @(negedge clk);
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        chk(seen_done, "R8 done seen", {31'h0, seen_done}, 32'h1);
        @(negedge clk);
        chk(req_done == 1'b0, "R8 done one cycle", {31'h0, req_done}, 32'h0);
        chk(per_stb == 1'b0, "R7 noise request ignored", {31'h0, per_stb}, 32'h0);
    endtask

    task automatic check_plan(input logic [AW-1:0] a, input logic [1:0] sz);
        int n;
        logic [AW-1:0] base;
        logic [1:0] eb;
        base = {a[AW-1:1], 1'b0};
        n = sz[1] ? (a[0] ? 3 : 2) : 1;
        chk(n_beats == n, sz[1] ? (a[0] ? "R2 beat count" : "R1 beat count") : "R5/R6 beat count",
            32'(n_beats), 32'(n));
        for (int k = 0; k < n && k < n_beats; k++) begin
            if (sz[1]) eb = a[0] ? ((k == 0) ? 2'b01 : (k == 1) ? 2'b11 : 2'b10) : 2'b11;
            else if (sz == 2'b01) eb = 2'b11;
            else eb = a[0] ? 2'b01 : 2'b10;
            chk(b_addr[k] == base + AW'(2 * k), "R10 R1 R2 location", 32'(b_addr[k]), 32'(base + AW'(2 * k)));
            chk(b_be[k] == eb, "R2 R5 R6 lane enables", 32'(b_be[k]), 32'(eb));
        end
    endtask

    task automatic check_mem(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < NB; i++) if (mem[i] !== exp_m[i]) bad = bad + 1;
        chk(bad == 0, req, 32'(bad), 32'h0);
    endtask

    initial begin
        logic [31:0] w, e;
        logic [AW-1:0] h;
        for (int i = 0; i < NB; i++) begin
            mem[i]   = 8'(i * 7 + 3);
            exp_m[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk(req_ready == 1'b1, "R11 ready", {31'h0, req_ready}, 32'h1);
        chk(per_stb == 1'b0, "R11 strobe", {31'h0, per_stb}, 32'h0);
        chk(req_done == 1'b0, "R11 done", {31'h0, req_done}, 32'h0);
        chk(req_rdata == 32'h0, "R11 rdata", req_rdata, 32'h0);

        for (int a = 0; a < NB; a++) begin
            logic [AW-1:0] aa;
            aa = AW'(a);
            // word write and read back (R1 R2 R3 R4 R10)
            w = (32'(a) * 32'h0101_0101) ^ 32'hA5C3_0F96;
            xact(aa, 2'b10, 1'b1, w, (a % 3) == 0);
            check_plan(aa, 2'b10);
            exp_m[aa] = w[31:24]; exp_m[aa + AW'(1)] = w[23:16];
            exp_m[aa + AW'(2)] = w[15:8]; exp_m[aa + AW'(3)] = w[7:0];
            check_mem("R3 word write bytes");
            chk(req_rdata == 32'h0, "R9 rdata zero after write", req_rdata, 32'h0);
            xact(aa, 2'b11, 1'b0, 32'h0, (a % 5) == 0);
            check_plan(aa, 2'b11);
            e = {exp_m[aa], exp_m[aa + AW'(1)], exp_m[aa + AW'(2)], exp_m[aa + AW'(3)]};
            chk(req_rdata == e, "R4 word read", req_rdata, e);
            repeat (2) @(negedge clk);
            chk(req_rdata == e, "R9 rdata held", req_rdata, e);

            // byte write and read (R5)
            w = 32'(a * 13 + 91);
            xact(aa, 2'b00, 1'b1, {24'hFFFFFF, w[7:0]}, 1'b0);
            check_plan(aa, 2'b00);
            exp_m[aa] = w[7:0];
            check_mem("R5 byte write");
            xact(aa, 2'b00, 1'b0, 32'h0, (a % 2) == 0);
            e = {24'h0, exp_m[aa]};
            chk(req_rdata == e, "R5 byte read", req_rdata, e);

            // halfword write and read (R6)
            h = {aa[AW-1:1], 1'b0};
            w = 32'(a * 257 + 4660);
            xact(aa, 2'b01, 1'b1, {16'hFFFF, w[15:0]}, 1'b0);
            check_plan(aa, 2'b01);
            exp_m[h] = w[15:8]; exp_m[h + AW'(1)] = w[7:0];
            check_mem("R6 halfword write");
            xact(aa, 2'b01, 1'b0, 32'h0, 1'b0);
            e = {16'h0, exp_m[h], exp_m[h + AW'(1)]};
            chk(req_rdata == e, "R6 halfword read", req_rdata, e);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule